// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A single-port synchronous memory whose inputs and outputs are all registered, built so that any mix of reads and writes can be issued on consecutive clocks without an idle cycle between them. Each active clock accepts an address, a read/write command, per-lane write enables, three chip selects and a load/advance control. The write data for a write command is presented two active clocks after the command itself. Read data leaves through an output register at the same two-clock distance. The data direction therefore never has to turn around on the bus.

A store-to-load bypass feeds a read with the data of a write that is still in flight, merged lane by lane with the array contents. A two-bit beat counter on the low address bits lets a four-beat burst run from one loaded address in linear or interleaved order. A clock enable freezes the whole block, outputs included. Lanes are `LANE_W` bits wide (9 by default, data plus parity). There are `LANES` of them (2 or 4), and the array holds 2^`AW` words.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low and after reset is released, `rdata_drive` is 0 and `rdata` is 0 until the first read completes.
- R2: A read accepted at an active edge puts the word on `rdata`, with `rdata_drive` high, at the second active edge after it.
- R3: A write accepted at an active edge takes `wdata` at the second active edge after it. Only lanes whose `be[i]` was 1 with the command are stored, where lane i is `wdata[LANE_W*i +: LANE_W]`. With `be` all 0, nothing is stored.
- R4: An edge with `clk_en` low changes no state. `rdata` and `rdata_drive` hold, and `wdata` presented then is not stored.
- R5: A load (`adv`=0) starts an access only if `sel_a`, `sel_b` and `sel_c` are all 1. Otherwise it is a deselect that stores nothing and leaves `rdata_drive` low two active edges later.
- R6: `rdata_drive` is high only for the completion of a read. It is low for the data phase of a write and of a deselect.
- R7: A read always returns the newest data written to its address, including a write accepted one or two active edges before it, merged per lane with older contents.
- R8: With `adv`=1 the block ignores `wr`, the selects and `addr`, and issues the next beat with the direction and validity of the last load. `be` is taken fresh on every beat.
- R9: With `ilv`=0, beat k of a burst loaded at address A uses low address bits (A[1:0]+k) mod 4, and the upper bits stay those of A.
- R10: With `ilv`=1, beat k uses low bits A[1:0] XOR (k mod 4). The burst wraps inside its four-word block after the fourth beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock qualifier; low freezes the block |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c | input | 1 | Chip select, active high |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| wr | input | 1 | 1 = write, 0 = read (on loads) |
| addr | input | AW | Word address |
| be | input | LANES | Per-lane write enables |
| ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata | input | LANES*LANE_W | Write data, two active edges after its command |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drive | output | 1 | High when rdata carries a completed read (bus drive enable) |

## Verification
The bench builds the block with two 9-bit lanes and a 4-bit address. With these values every word can be written and read back in a sweep. Every lane-enable pattern is applied and every non-selecting chip-select combination is tried. Every start offset of a four-word block is run in both burst orders. A long pseudo-random phase then mixes reads, writes, bursts, stalls and deselects at that small depth, so address collisions inside the two-stage write pipeline happen often and exercise the bypass.

// File: rtl/zt_pkg.sv
package zt_pkg;

   // Low two address bits of a burst beat: XOR of start and count when
   // interleaved, wrapping sum otherwise.
   function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
      return ilv ? (start ^ cnt) : (start + cnt);
   endfunction

endpackage

// File: rtl/zt_addr_seq.sv
module zt_addr_seq #(
   parameter int LANES = 4,
   parameter int AW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             adv,
   input  logic             sel_all,
   input  logic             wr,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] be,
   input  logic             ilv,
   output logic             s1_vld,
   output logic             s1_wr,
   output logic [AW-1:0]    s1_addr,
   output logic [LANES-1:0] s1_be
);
   import zt_pkg::*;

   logic          b_vld, b_wr;
   logic [AW-1:0] b_base;
   logic [1:0]    b_cnt;

   logic          n_vld, n_wr;
   logic [AW-1:0] n_base;
   logic [1:0]    n_cnt;
   logic [AW-1:0] n_addr;

   always_comb begin
      if (!adv) begin
         n_vld  = sel_all;
         n_wr   = sel_all & wr;
         n_base = addr;
         n_cnt  = 2'd0;
      end else begin
         n_vld  = b_vld;
         n_wr   = b_wr;
         n_base = b_base;
         n_cnt  = b_cnt + 2'd1;
      end
      n_addr = {n_base[AW-1:2], beat_lo(n_base[1:0], n_cnt, ilv)};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_vld   <= 1'b0;
         b_wr    <= 1'b0;
         b_base  <= '0;
         b_cnt   <= 2'd0;
         s1_vld  <= 1'b0;
         s1_wr   <= 1'b0;
         s1_addr <= '0;
         s1_be   <= '0;
      end else if (clk_en) begin
         b_vld   <= n_vld;
         b_wr    <= n_wr;
         b_base  <= n_base;
         b_cnt   <= n_cnt;
         s1_vld  <= n_vld;
         s1_wr   <= n_wr;
         s1_addr <= n_addr;
         s1_be   <= be;
      end
   end

   AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !adv && !sel_all) |=> !s1_vld); // R5
   AST_BURST_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv) |=> (s1_vld == $past(s1_vld) && s1_wr == $past(s1_wr))); // R8
   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv && !ilv) |=> (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1)); // R9
   AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2]))); // R10

endmodule

// File: rtl/zt_store.sv
module zt_store #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int AW     = 6
) (
   input  logic                    clk,
   input  logic                    clk_en,
   input  logic                    rd_vld,
   input  logic [AW-1:0]           rd_addr,
   input  logic                    cm_vld,
   input  logic [AW-1:0]           cm_addr,
   input  logic [LANES-1:0]        cm_be,
   input  logic [LANES*LANE_W-1:0] cm_data,
   output logic [LANES*LANE_W-1:0] rd_q
);
   localparam int DEPTH = 1 << AW;

   logic hit;
   assign hit = cm_vld && (cm_addr == rd_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];
      logic [LANE_W-1:0] lane_q;
      logic [LANE_W-1:0] lane_in;

      assign lane_in = cm_data[g*LANE_W +: LANE_W];

      always_ff @(posedge clk) begin
         if (clk_en && cm_vld && cm_be[g])
            bank[cm_addr] <= lane_in;
      end

      // Array read one stage early; a write committing on the same edge
      // is bypassed lane by lane so the read sees the newest value.
      always_ff @(posedge clk) begin
         if (clk_en && rd_vld)
            lane_q <= (hit && cm_be[g]) ? lane_in : bank[rd_addr];
      end

      assign rd_q[g*LANE_W +: LANE_W] = lane_q;
   end

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int AW     = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en,
   input  logic                    sel_a,
   input  logic                    sel_b,
   input  logic                    sel_c,
   input  logic                    adv,
   input  logic                    wr,
   input  logic [AW-1:0]           addr,
   input  logic [LANES-1:0]        be,
   input  logic                    ilv,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_drive
);
   localparam int DW = LANES * LANE_W;

   initial begin
      if (LANES != 2 && LANES != 4) $fatal(1, "zt_sram: LANES must be 2 or 4");
      if (AW < 3)                   $fatal(1, "zt_sram: AW must be at least 3");
      if (LANE_W < 1)               $fatal(1, "zt_sram: LANE_W must be positive");
   end

   logic             sel_all;
   logic             s1_vld, s1_wr;
   logic [AW-1:0]    s1_addr;
   logic [LANES-1:0] s1_be;
   logic             s2_vld, s2_wr;
   logic [AW-1:0]    s2_addr;
   logic [LANES-1:0] s2_be;
   logic [DW-1:0]    rd_q;

   assign sel_all = sel_a & sel_b & sel_c;

   zt_addr_seq #(.LANES(LANES), .AW(AW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_en  (clk_en),
      .adv     (adv),
      .sel_all (sel_all),
      .wr      (wr),
      .addr    (addr),
      .be      (be),
      .ilv     (ilv),
      .s1_vld  (s1_vld),
      .s1_wr   (s1_wr),
      .s1_addr (s1_addr),
      .s1_be   (s1_be)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_vld  <= 1'b0;
         s2_wr   <= 1'b0;
         s2_addr <= '0;
         s2_be   <= '0;
      end else if (clk_en) begin
         s2_vld  <= s1_vld;
         s2_wr   <= s1_wr;
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
      end
   end

   zt_store #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_store (
      .clk     (clk),
      .clk_en  (clk_en),
      .rd_vld  (s1_vld & ~s1_wr),
      .rd_addr (s1_addr),
      .cm_vld  (s2_vld & s2_wr),
      .cm_addr (s2_addr),
      .cm_be   (s2_be),
      .cm_data (wdata),
      .rd_q    (rd_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata       <= '0;
         rdata_drive <= 1'b0;
      end else if (clk_en) begin
         rdata_drive <= s2_vld & ~s2_wr;
         if (s2_vld && !s2_wr)
            rdata <= rd_q;
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(rdata) && $stable(rdata_drive))); // R4
   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && s2_vld && s2_wr) |=> !rdata_drive); // R6
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!rdata_drive && rdata == '0)); // R1

endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
   localparam int LANES = 2;
   localparam int LW    = 9;
   localparam int AW    = 4;
   localparam int DW    = LANES * LW;
   localparam int DEPTH = 1 << AW;

   logic clk, rst_n, clk_en, sel_a, sel_b, sel_c, adv, wr, ilv;
   logic [AW-1:0]    addr;
   logic [LANES-1:0] be;
   logic [DW-1:0]    wdata, rdata;
   logic             rdata_drive;

   zt_sram #(.LANES(LANES), .LANE_W(LW), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_a(sel_a), .sel_b(sel_b),
      .sel_c(sel_c), .adv(adv), .wr(wr), .addr(addr), .be(be), .ilv(ilv),
      .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   typedef struct packed {
      logic             v;
      logic             w;
      logic [AW-1:0]    a;
      logic [LANES-1:0] be;
      logic [DW-1:0]    d;
   } ent_t;

   logic [DW-1:0] mm [DEPTH];
   ent_t          q0, q1;
   logic          mb_v, mb_w;
   logic [AW-1:0] mb_base;
   logic [1:0]    mb_cnt;
   logic [31:0]   seed;
   int            n_chk, n_err;

   function automatic logic [DW-1:0] nextval();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed[31:32-DW];
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, check after the next one.
   task automatic step(input logic ce, input logic ad, input logic [2:0] sels,
                       input logic w, input logic [AW-1:0] a,
                       input logic [LANES-1:0] b, input logic o, input string req);
      ent_t          n;
      logic [DW-1:0] pd;
      logic          po;
      logic [1:0]    k;
      clk_en = ce; adv = ad; {sel_c, sel_b, sel_a} = sels;
      wr = w; addr = a; be = b; ilv = o;
      if (!ce) begin
         pd = rdata; po = rdata_drive;
         wdata = ~q1.d;
         @(posedge clk); @(negedge clk);
         chk(req, "stalled data", rdata, pd);
         chk(req, "stalled drive", {{(DW-1){1'b0}}, rdata_drive}, {{(DW-1){1'b0}}, po});
         return;
      end
      wdata = (q1.v && q1.w) ? q1.d : nextval();
      n = '0;
      if (!ad) begin
         n.v = &sels; n.w = w & n.v; mb_base = a; mb_cnt = 2'd0;
      end else begin
         n.v = mb_v; n.w = mb_w; mb_cnt = mb_cnt + 2'd1;
      end
      k = o ? (mb_base[1:0] ^ mb_cnt) : (mb_base[1:0] + mb_cnt);
      n.a = {mb_base[AW-1:2], k};
      n.be = b;
      n.d = n.w ? nextval() : '0;
      mb_v = n.v; mb_w = n.w;
      @(posedge clk); @(negedge clk);
      if (q1.v && q1.w)
         for (int i = 0; i < LANES; i++)
            if (q1.be[i]) mm[q1.a][i*LW +: LW] = q1.d[i*LW +: LW];
      chk(req, "drive", {{(DW-1){1'b0}}, rdata_drive}, {{(DW-1){1'b0}}, q1.v & ~q1.w});
      if (q1.v && !q1.w) chk(req, "read data", rdata, mm[q1.a]);
      q1 = q0; q0 = n;
   endtask

   task automatic wr1(input logic [AW-1:0] a, input logic [LANES-1:0] b, input string req);
      step(1'b1, 1'b0, 3'b111, 1'b1, a, b, 1'b0, req);
   endtask
   task automatic rd1(input logic [AW-1:0] a, input string req);
      step(1'b1, 1'b0, 3'b111, 1'b0, a, '1, 1'b0, req);
   endtask
   task automatic idle(input string req);
      step(1'b1, 1'b0, 3'b000, 1'b0, '0, '0, 1'b0, req);
   endtask
   task automatic stall(input string req);
      step(1'b0, 1'b0, 3'b111, 1'b1, '1, '1, 1'b0, req);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_err++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      n_chk = 0; n_err = 0; seed = 32'h1234_5678;
      q0 = '0; q1 = '0; mb_v = 1'b0; mb_w = 1'b0; mb_base = '0; mb_cnt = 2'd0;
      rst_n = 1'b0; clk_en = 1'b0; sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0;
      adv = 1'b0; wr = 1'b0; addr = '0; be = '0; ilv = 1'b0; wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "drive in reset", {{(DW-1){1'b0}}, rdata_drive}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "data after reset", rdata, '0);
      chk("R1", "drive after reset", {{(DW-1){1'b0}}, rdata_drive}, '0);
      idle("R1"); idle("R1");

      // full sweep of writes then reads
      for (int a = 0; a < DEPTH; a++) wr1(AW'(a), '1, "R3");
      idle("R3"); idle("R3");
      for (int a = 0; a < DEPTH; a++) rd1(AW'(a), "R2");
      idle("R2"); idle("R2");

      // every lane-enable pattern, including none
      for (int a = 0; a < DEPTH; a++) wr1(AW'(a), LANES'(a), "R3");
      idle("R3"); idle("R3");
      for (int a = 0; a < DEPTH; a++) rd1(AW'(a), "R3");
      idle("R3"); idle("R3");

      // read after write at gaps 0..2, partial and double writes
      for (int gap = 0; gap < 3; gap++)
         for (int a = 0; a < DEPTH; a++) begin
            wr1(AW'(a), LANES'(a + gap), "R7");
            if (a[0]) wr1(AW'(a), LANES'(a + 1), "R7");
            for (int i = 0; i < gap; i++) idle("R7");
            rd1(AW'(a), "R7");
         end
      idle("R7"); idle("R7");

      // clock-enable stalls in the middle of the pipeline
      wr1(4'd3, '1, "R4"); stall("R4"); stall("R4"); stall("R4");
      idle("R4"); stall("R4"); stall("R4");
      rd1(4'd3, "R4"); stall("R4"); idle("R4"); stall("R4");
      idle("R4"); stall("R4"); idle("R4");

      // every non-selecting chip-select combination
      for (int c = 0; c < 7; c++) begin
         step(1'b1, 1'b0, 3'(c), 1'b1, 4'd5, '1, 1'b0, "R5");
         idle("R5"); idle("R5");
         rd1(4'd5, "R5");
         idle("R5"); idle("R5");
      end

      // alternating writes and reads, no gaps
      for (int a = 0; a < DEPTH; a++) begin
         wr1(AW'(a), '1, "R6");
         rd1(AW'(a ^ 1), "R6");
      end
      idle("R6"); idle("R6");

      // bursts in both orders from every start offset
      for (int o = 0; o < 2; o++)
         for (int s = 0; s < 4; s++) begin
            string rq;
            logic [AW-1:0] ba;
            rq = o ? "R10" : "R9";
            ba = {2'(o + 1), 2'(s)};
            step(1'b1, 1'b0, 3'b111, 1'b1, ba, '1, 1'(o), rq);
            for (int k = 0; k < 3; k++)
               step(1'b1, 1'b1, 3'b000, 1'b0, ~ba, '1, 1'(o), "R8");
            idle(rq); idle(rq);
            for (int k = 0; k < 4; k++) rd1({ba[AW-1:2], 2'(k)}, rq);
            step(1'b1, 1'b0, 3'b111, 1'b0, ba, '1, 1'(o), rq);
            for (int k = 0; k < 5; k++)
               step(1'b1, 1'b1, 3'b000, 1'b1, ~ba, '0, 1'(o), rq);
            idle(rq); idle(rq);
         end

      // advancing after a deselect writes nothing
      idle("R8");
      for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 3'b111, 1'b1, 4'd8, '1, 1'b0, "R8");
      idle("R8"); idle("R8");
      for (int a = 8; a < 12; a++) rd1(AW'(a), "R8");
      idle("R8"); idle("R8");

      // pseudo-random mix; burst order fixed per half
      for (int h = 0; h < 2; h++)
         for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = {nextval(), 14'h0} ^ seed;
            step(r[3:0] != 4'd0, r[5:4] == 2'd0, (r[8:6] == 3'd0) ? r[11:9] : 3'b111,
                 r[12], r[16:13], r[18:17], 1'(h), "R7");
         end
      idle("R7"); idle("R7");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule